// File: doc/BRIEF.md
# Configuration Record Checksum Validator

This block watches the bytes of a board identity record as they are read, in order, from the start of a serial configuration memory. It sums every byte the record covers and checks that sum against the stored check byte. It collects the 64-bit unique identifier and screens it. When the record is complete, it reports the verdict and the corrected identifier together, with a single-cycle completion pulse.

The record declares its own length in one of its bytes. The positions of the length byte, the check byte and the identifier field are parameters. The check value is the 8-bit wrapping sum of all covered bytes, less the stored check byte, bit-inverted. The identifier is big-endian: its first octet is the most significant.

Identifiers made entirely of zeros or entirely of ones are refused. One known placeholder identifier is accepted but raises a warning. Some records use an older layout in which the top three octets are zero. For those, the block moves the two following octets up by two positions, so that the repaired identifier comes out directly.

Top module: `cfgrec_check`

## Requirements
- R1: While reset is held and after it is released, `res_done`, `res_csum_ok`, `res_id_ok`, `res_id_warn` are 0 and `res_id` is all zero.
- R2: A byte is taken when `rec_vld` is high. A byte taken with `rec_sof` high is record index 0 and restarts any open record. Bytes with `rec_vld` high while no record is open and `rec_sof` low are ignored: they raise no `res_done` and change no output.
- R3: The byte at index LEN_OFF (default 1) gives the record length N. The record ends with the byte at index N-1. `res_done` is high for exactly one cycle, in the cycle after that byte is taken. All result outputs hold their values until the next `res_done`.
- R4: The check byte sits at index CSUM_OFF (default 2). `res_csum_ok` is 1 exactly when the bitwise inverse of ((sum of bytes 0..N-1) minus the check byte), taken modulo 256, equals the check byte.
- R5: If N is below the minimum length (default 11, which is the end of the identifier field), the record ends on the length byte itself. The block then reports `res_csum_ok`=0, `res_id_ok`=0, `res_id_warn`=0 and `res_id`=0.
- R6: The identifier is the eight bytes at indices ID_OFF..ID_OFF+7 (default 3..10). The byte at ID_OFF is octet 0, which becomes bits 63:56. `res_id_ok` is 1 only when the check byte is good and the raw identifier is neither all zeros nor all ones.
- R7: `res_id_warn` is 1 exactly when `res_id_ok` is 1 and the raw identifier equals DEF_ID (default 64'h0011_7500_0000_0001).
- R8: When raw octets 0, 1 and 2 are all zero, `res_id` carries raw octet 3 in octet 1 and raw octet 4 in octet 2, zeros in octets 3 and 4, and octets 0, 5, 6 and 7 unchanged. Otherwise `res_id` equals the raw identifier.
- R9: Idle cycles (`rec_vld` low) between the bytes of a record do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_sof | input | 1 | Marks the first byte of a record; only acts together with `rec_vld` |
| rec_vld | input | 1 | `rec_byte` carries a record byte this cycle |
| rec_byte | input | 8 | Record byte |
| res_done | output | 1 | One-cycle pulse: the results below are new |
| res_csum_ok | output | 1 | Check byte matches |
| res_id_ok | output | 1 | Identifier accepted |
| res_id_warn | output | 1 | Identifier is the placeholder value |
| res_id | output | 64 | Identifier after the older-layout repair |

## Verification
The main function is driven with records that differ in one aspect at a time. A good record is set against the same record with one check bit flipped, which separates correct summing from a checker that ignores the check byte. All-zero, all-one, placeholder and older-layout identifiers carry valid check bytes, so the identifier rules are tested apart from the checksum. Lengths just below and at the minimum, zero and the largest value show whether the block ends on the length byte and whether it sums exactly N bytes. Randomized records with idle gaps, stray bytes between records and a restart in mid-record show whether framing and gap handling leak into the sum.

// File: rtl/cfgrec_pkg.sv
// Shared types and the identifier repair function for the record validator.
// Assumes an identifier of eight octets, octet 0 most significant.
package cfgrec_pkg;

    localparam int OCTETS = 8;
    localparam int ID_W   = 8 * OCTETS;
    localparam int IDX_W  = 8;

    typedef logic [7:0] octet_t;

    typedef struct packed {
        logic            csum_ok;
        logic            id_ok;
        logic            warn;
        logic [ID_W-1:0] id;
    } verdict_t;

    // Move octets 3 and 4 up to 1 and 2 when the top three octets are zero.
    function automatic logic [ID_W-1:0] mend_legacy(input logic [ID_W-1:0] raw);
        octet_t          o [0:OCTETS-1];
        logic [ID_W-1:0] r;
        for (int i = 0; i < OCTETS; i++) begin
            o[i] = raw[ID_W-1-8*i -: 8];
        end
        if (o[0] == 8'h00 && o[1] == 8'h00 && o[2] == 8'h00) begin
            o[1] = o[3];
            o[2] = o[4];
            o[3] = 8'h00;
            o[4] = 8'h00;
        end
        for (int i = 0; i < OCTETS; i++) begin
            r[ID_W-1-8*i -: 8] = o[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgrec_tracker.sv
// Record framing: decides which bytes belong to the open record, gives each
// its index, latches the length byte and flags the final byte.
// Assumes MIN_LEN > LEN_OFF and a length that fits in one byte.
module cfgrec_tracker
    import cfgrec_pkg::*;
#(
    parameter int LEN_OFF = 1,
    parameter int MIN_LEN = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             vld,
    input  logic [7:0]       data,
    output logic             take,
    output logic [IDX_W-1:0] cur_idx,
    output logic             last,
    output logic             short_rec
);

    localparam logic [IDX_W-1:0] LEN_IDX = IDX_W'(LEN_OFF);
    localparam logic [7:0]       MIN_B   = 8'(MIN_LEN);

    logic             active;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       len_q;
    logic [7:0]       len_cur;
    logic             at_len;

    // Classify the incoming byte and spot the end of the record.
    always_comb begin
        take      = vld && (sof || active);
        cur_idx   = sof ? '0 : idx_q;
        at_len    = (cur_idx == LEN_IDX);
        len_cur   = at_len ? data : len_q;
        short_rec = take && at_len && (data < MIN_B);
        last      = take && (short_rec ||
                    ((cur_idx >= LEN_IDX) &&
                     ({1'b0, cur_idx} + 9'd1 == {1'b0, len_cur})));
    end

    // Open/close the record and advance the byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx_q  <= '0;
        end else if (take) begin
            active <= !last;
            idx_q  <= cur_idx + 1'b1;
        end
    end

    // Keep the declared length once its byte has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (take && at_len) begin
            len_q <= data;
        end
    end

    // R2: with no record open and no start marker, the index cannot move.
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(vld && sof)) |=> (idx_q == $past(idx_q)));

endmodule

// File: rtl/cfgrec_csum.sv
// Running 8-bit sum of the record bytes plus capture of the stored check
// byte. Exposes next-state values so the verdict can be formed at the edge
// that takes the final byte.
module cfgrec_csum
    import cfgrec_pkg::*;
#(
    parameter int CSUM_OFF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             sof,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [7:0]       data,
    output logic [7:0]       sum_nxt,
    output logic [7:0]       stored_nxt
);

    localparam logic [IDX_W-1:0] CS_IDX = IDX_W'(CSUM_OFF);

    logic [7:0] sum_q;
    logic [7:0] stored_q;

    // Fold the current byte into the sum; a start marker restarts it.
    always_comb begin
        sum_nxt    = sum_q;
        stored_nxt = stored_q;
        if (take) begin
            sum_nxt = (sof ? 8'h00 : sum_q) + data;
            if (cur_idx == CS_IDX) begin
                stored_nxt = data;
            end
        end
    end

    // Register the sum and the check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q    <= '0;
            stored_q <= '0;
        end else begin
            sum_q    <= sum_nxt;
            stored_q <= stored_nxt;
        end
    end

endmodule

// File: rtl/cfgrec_idcap.sv
// Collects the eight identifier octets by index, octet 0 into the top byte.
// One register lane per octet, each loading only at its own index.
module cfgrec_idcap
    import cfgrec_pkg::*;
#(
    parameter int ID_OFF = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [7:0]       data,
    output logic [ID_W-1:0]  id_nxt
);

    logic [ID_W-1:0] id_q;

    for (genvar k = 0; k < OCTETS; k++) begin : g_lane
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ID_OFF + k);

        // Pick this octet's new value when its index comes by.
        always_comb begin
            id_nxt[ID_W-1-8*k -: 8] = (take && cur_idx == MY_IDX) ?
                                      data : id_q[ID_W-1-8*k -: 8];
        end

        // Hold this octet.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                id_q[ID_W-1-8*k -: 8] <= '0;
            end else begin
                id_q[ID_W-1-8*k -: 8] <= id_nxt[ID_W-1-8*k -: 8];
            end
        end
    end

endmodule

// File: rtl/cfgrec_check.sv
// Top of the record validator. Frames the byte stream, sums it, gathers the
// identifier and registers a verdict on the edge that takes the last byte.
// Assumes the check byte lies outside the identifier field and that all
// field offsets are below 255.
module cfgrec_check
    import cfgrec_pkg::*;
#(
    parameter int              LEN_OFF  = 1,
    parameter int              CSUM_OFF = 2,
    parameter int              ID_OFF   = 3,
    parameter logic [ID_W-1:0] DEF_ID   = 64'h0011_7500_0000_0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rec_sof,
    input  logic            rec_vld,
    input  logic [7:0]      rec_byte,
    output logic            res_done,
    output logic            res_csum_ok,
    output logic            res_id_ok,
    output logic            res_id_warn,
    output logic [ID_W-1:0] res_id
);

    localparam int END_CS  = CSUM_OFF + 1;
    localparam int END_ID  = ID_OFF + OCTETS;
    localparam int END_LEN = LEN_OFF + 1;
    localparam int END_AB  = (END_CS > END_ID) ? END_CS : END_ID;
    localparam int MIN_LEN = (END_AB > END_LEN) ? END_AB : END_LEN;

    logic             take;
    logic [IDX_W-1:0] cur_idx;
    logic             last;
    logic             short_rec;
    logic [7:0]       sum_nxt;
    logic [7:0]       stored_nxt;
    logic [ID_W-1:0]  id_nxt;
    logic [7:0]       cs_calc;
    logic             raw_bad;
    verdict_t         verdict;
    verdict_t         res_q;
    logic             done_q;

    cfgrec_tracker #(.LEN_OFF(LEN_OFF), .MIN_LEN(MIN_LEN)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (rec_sof),
        .vld       (rec_vld),
        .data      (rec_byte),
        .take      (take),
        .cur_idx   (cur_idx),
        .last      (last),
        .short_rec (short_rec)
    );

    cfgrec_csum #(.CSUM_OFF(CSUM_OFF)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .sof        (rec_sof),
        .cur_idx    (cur_idx),
        .data       (rec_byte),
        .sum_nxt    (sum_nxt),
        .stored_nxt (stored_nxt)
    );

    cfgrec_idcap #(.ID_OFF(ID_OFF)) u_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .cur_idx (cur_idx),
        .data    (rec_byte),
        .id_nxt  (id_nxt)
    );

    // Form the verdict from the totals that include the final byte.
    always_comb begin
        cs_calc         = ~(sum_nxt - stored_nxt);
        raw_bad         = (id_nxt == '0) || (id_nxt == '1);
        verdict.csum_ok = !short_rec && (cs_calc == stored_nxt);
        verdict.id_ok   = verdict.csum_ok && !raw_bad;
        verdict.warn    = verdict.id_ok && (id_nxt == DEF_ID);
        verdict.id      = short_rec ? '0 : mend_legacy(id_nxt);
    end

    // Latch the verdict and pulse completion on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            res_q  <= '0;
        end else begin
            done_q <= last;
            if (last) begin
                res_q <= verdict;
            end
        end
    end

    assign res_done    = done_q;
    assign res_csum_ok = res_q.csum_ok;
    assign res_id_ok   = res_q.id_ok;
    assign res_id_warn = res_q.warn;
    assign res_id      = res_q.id;

    // R6: an accepted identifier needs a good check byte.
    p_id_needs_csum_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_id_ok |-> res_csum_ok);

    // R7: the placeholder warning only accompanies an accepted identifier.
    p_warn_needs_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_id_warn |-> res_id_ok);

    // R3: results move only together with the completion pulse.
    p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> $stable({res_csum_ok, res_id_ok, res_id_warn, res_id}));

    // R8: the repair never turns an accepted identifier into zero.
    p_id_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_id_ok |-> (res_id != '0));

endmodule

// File: tb/cfgrec_check_test.sv
// Bench for cfgrec_check: directed corner records plus seeded random records,
// compared against a bench-side model of the requirements.
module cfgrec_check_test;

    localparam logic [63:0] DEF = 64'h0011_7500_0000_0001;
    localparam int MINL = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        vld = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        done, cok, iok, warn;
    logic [63:0] idv;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] rec [0:255];

    cfgrec_check uut (
        .clk(clk), .rst_n(rst_n), .rec_sof(sof), .rec_vld(vld), .rec_byte(din),
        .res_done(done), .res_csum_ok(cok), .res_id_ok(iok),
        .res_id_warn(warn), .res_id(idv)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic void put_id(input logic [63:0] v);
        for (int i = 0; i < 8; i++) rec[3+i] = v[63-8*i -: 8];
    endfunction

    function automatic logic [63:0] get_id();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[63-8*i -: 8] = rec[3+i];
        return v;
    endfunction

    // Make the check byte correct for a record of n bytes.
    function automatic void seal(input int n);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < n; i++) if (i != 2) s += rec[i];
        rec[2] = ~s;
    endfunction

    function automatic void fill(input int n, input logic [63:0] id);
        for (int i = 0; i < 256; i++) rec[i] = 8'($urandom);
        rec[1] = 8'(n);
        put_id(id);
        seal(n);
    endfunction

    // Send a record; bytes after the record end are not sent.
    task automatic send_and_check(input string what, input bit gaps);
        int n = int'(rec[1]);
        int cnt = (n < MINL) ? 2 : n;
        bit early = 1'b0;
        logic [7:0] s = 8'h00;
        logic [63:0] raw = get_id();
        logic e_cok, e_iok, e_warn;
        logic [63:0] e_id;
        for (int i = 0; i < cnt; i++) begin
            sof = (i == 0); vld = 1'b1; din = rec[i];
            @(negedge clk);
            if (done && i < cnt - 1) early = 1'b1;
            sof = 1'b0;
            if (gaps && i < cnt - 1) begin
                vld = 1'b0;
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    if (done) early = 1'b1;
                end
            end
        end
        vld = 1'b0;
        if (n < MINL) begin
            e_cok = 0; e_iok = 0; e_warn = 0; e_id = '0;
        end else begin
            for (int i = 0; i < n; i++) s += rec[i];
            e_cok  = (~(s - rec[2]) == rec[2]);
            e_iok  = e_cok && raw != '0 && raw != '1;
            e_warn = e_iok && raw == DEF;
            e_id   = (raw[63:40] == 24'h0) ?
                     {8'h00, raw[39:32], raw[31:24], 16'h0000, raw[23:0]} : raw;
        end
        chk({"R3 no early done ", what}, 64'(early), 64'd0);
        chk({"R3 done pulse ", what}, 64'(done), 64'd1);
        chk({"R4 csum_ok ", what}, 64'(cok), 64'(e_cok));
        chk({"R6 id_ok ", what}, 64'(iok), 64'(e_iok));
        chk({"R7 warn ", what}, 64'(warn), 64'(e_warn));
        chk({"R8 id ", what}, idv, e_id);
        @(negedge clk);
        chk({"R3 done one cycle ", what}, 64'(done), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] keep;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 flags", {61'd0, cok, iok, warn}, 64'd0);
        chk("R1 id", idv, 64'd0);

        fill(16, 64'h0123_4567_89ab_cdef); send_and_check("good", 0);
        fill(16, 64'h0123_4567_89ab_cdef); rec[2] ^= 8'h01; send_and_check("R4 bad csum", 0);
        fill(20, 64'h0); send_and_check("R6 zero id", 0);
        fill(20, '1); send_and_check("R6 ones id", 0);
        fill(14, DEF); send_and_check("R7 default id", 0);
        fill(12, 64'h0000_00a1_b2c3_d4e5); send_and_check("R8 legacy", 0);
        chk("R8 legacy value", idv, 64'h00a1_b200_00c3_d4e5);
        fill(12, 64'h0000_01a1_b2c3_d4e5); send_and_check("R8 near legacy", 0);
        fill(5, 64'h1111_2222_3333_4444); send_and_check("R5 short 5", 0);
        fill(0, 64'h1111_2222_3333_4444); send_and_check("R5 zero len", 0);
        fill(10, 64'h1111_2222_3333_4444); send_and_check("R5 len 10", 0);
        fill(11, 64'h1111_2222_3333_4444); send_and_check("R5 len 11", 0);
        fill(255, 64'h5555_6666_7777_8888); send_and_check("R3 len 255", 0);
        fill(30, 64'h0a0b_0c0d_0e0f_1011); send_and_check("R9 gaps", 1);

        // R2: stray bytes while no record is open.
        keep = idv;
        for (int i = 0; i < 6; i++) begin
            sof = 1'b0; vld = 1'b1; din = 8'(i + 3);
            @(negedge clk);
            chk("R2 stray no done", 64'(done), 64'd0);
        end
        vld = 1'b0;
        @(negedge clk);
        chk("R2 stray id held", idv, keep);

        // R2: restart in mid-record.
        for (int i = 0; i < 7; i++) begin
            sof = (i == 0); vld = 1'b1; din = (i == 1) ? 8'd40 : 8'($urandom);
            @(negedge clk);
        end
        fill(18, 64'hfeed_0000_beef_0001); send_and_check("R2 restart", 0);

        for (int t = 0; t < 150; t++) begin
            int n = 11 + ($urandom % 70);
            logic [63:0] id = {$urandom, $urandom};
            case ($urandom % 6)
                0: id = DEF;
                1: id[63:40] = '0;
                2: id = '0;
                default: ;
            endcase
            fill(n, id);
            if ($urandom % 10 < 3) rec[$urandom % n] ^= 8'(1 << ($urandom % 8));
            if ($urandom % 12 == 0) rec[1] = 8'($urandom % 11);
            send_and_check("random", ($urandom % 2) == 1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule